// File: doc/BRIEF.md
# Dual-Clock FIFO Read-Side Flag Controller

This block runs the read half of a FIFO whose write side lives in another clock domain. The write side exports its pointer as a Gray code. The block carries that pointer into the read clock through a flop chain, compares it with its own read pointer, and from that comparison drives three things: the read address into the storage array, a one-cycle fetch strobe, and an output data register with one status flag. The storage array, the full flag and any width conversion sit outside this block.

Two behaviours are offered, and the choice is latched once after reset. In the plain mode the flag means "not empty", and a word moves into the output register only when an explicit read is accepted. In the look-ahead mode the flag means "output valid". The head word is pulled into the output register on its own, so the consumer sees it before it reads, and an accepted read simply retires the word on display. Because the write pointer is resynchronised, how close the write edge falls to a read edge decides whether the flag moves on a given read edge or on the one after it.

Top module: `fifo_rd_flag`

## Requirements
- R1: While `rrst_n` is low, and after it is released, `flag` is 0, `dout` is all zeros and `rd_inc` is 0 until data arrives.
- R2: In look-ahead mode, when `wr_ptr_gray` changes between two read edges on an empty FIFO, `flag` rises on the third following `rclk` edge (the edge that first captures the pointer counts as the first), and `dout` holds the new word from that same edge.
- R3: In plain mode, the same write makes `flag` rise on the third following edge, and `dout` keeps its old value until a read is accepted. After an accepted read, `dout` shows the word at the head.
- R4: A read is accepted only on an `rclk` edge where `rd_cs`, `rd_dir` (1 = read) and `rd_en` are all 1. If any of them is 0, `dout` and `flag` are left unchanged.
- R5: A read request made while `flag` is 0 is ignored: `rd_inc` stays 0 and `ram_raddr` does not move.
- R6: `flag` falls on the edge that accepts the read of the last stored word.
- R7: In look-ahead mode, while `flag` is 0, `dout` keeps the last word it showed.
- R8: Words come out in the order they were written, including when the pointers wrap past `DEPTH`.
- R9: `fwft_sel` is sampled on the first `rclk` edge after reset release (1 = look-ahead). Later changes have no effect until the next reset.
- R10: `rd_inc` is 1 exactly in the cycles in which a word is fetched from `ram_rdata` into `dout`, and `ram_raddr` steps by one, modulo `DEPTH`, after each such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Asynchronous reset, active low |
| fwft_sel | input | 1 | Mode request: 1 = look-ahead, 0 = plain; latched after reset |
| wr_ptr_gray | input | AW+1 | Write pointer from the write domain, Gray coded |
| rd_cs | input | 1 | Chip select for the read port |
| rd_dir | input | 1 | Direction: 1 = read |
| rd_en | input | 1 | Read enable |
| ram_rdata | input | DW | Word at `ram_raddr`, from the storage array (combinational) |
| ram_raddr | output | AW | Read address into the storage array |
| rd_inc | output | 1 | Fetch strobe; the read pointer advances on the next edge |
| dout | output | DW | Output data register |
| flag | output | 1 | Plain mode: not empty. Look-ahead mode: output valid |

## Verification
The hardest case to reach is the exact edge on which the flag moves after a write into an empty FIFO. That edge depends on where the write-pointer update falls relative to the read clock. The bench therefore changes the Gray pointer at a fixed point in the middle of a read cycle, which removes the uncertain slip, and then samples the flag and the data after each of the next three read edges. A queue-based scoreboard follows a stream long enough to wrap the pointers. Partial read qualifiers, reads on an empty FIFO and a mode change after reset are each applied with a word on display, so any unwanted effect on the outputs is visible.

// File: rtl/fifo_rd_flag.sv
module fifo_rd_flag #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          fwft_sel,
  input  logic [PW-1:0] wr_ptr_gray,
  input  logic          rd_cs,
  input  logic          rd_dir,
  input  logic          rd_en,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ram_raddr,
  output logic          rd_inc,
  output logic [DW-1:0] dout,
  output logic          flag
);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] sync_q [SYNC];
  logic [PW-1:0] rptr;
  logic          started, fwft_q, flag_q;
  logic [DW-1:0] dout_q;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= wr_ptr_gray;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  wire [PW-1:0] wbin  = g2b(sync_q[SYNC-1]);
  wire          avail = wbin != rptr;
  wire          req   = rd_cs & rd_dir & rd_en;
  wire          take  = req & flag_q;
  wire          fetch = started & (fwft_q ? (avail & (~flag_q | take)) : take);
  wire [PW-1:0] rptr_nx = rptr + PW'(fetch);
  wire          flag_d  = started & (fwft_q ? (fetch | (flag_q & ~take))
                                             : (wbin != rptr_nx));

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      started <= 1'b0;
      fwft_q  <= 1'b0;
      rptr    <= '0;
      flag_q  <= 1'b0;
      dout_q  <= '0;
    end else begin
      if (!started) begin
        started <= 1'b1;
        fwft_q  <= fwft_sel;
      end
      rptr   <= rptr_nx;
      flag_q <= flag_d;
      if (fetch) dout_q <= ram_rdata;
    end
  end

  assign ram_raddr = rptr[AW-1:0];
  assign rd_inc    = fetch;
  assign dout      = dout_q;
  assign flag      = flag_q;

  p_empty_read_ignored_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (started && !fwft_q && !flag_q) |=> $stable(rptr));

  p_hold_when_dry_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (started && !flag_q && wbin == rptr) |=> $stable(dout_q));

  p_addr_step_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_inc |=> (ram_raddr == AW'($past(ram_raddr) + 1'b1)));

  p_mode_locked_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    (started && $past(started)) |-> $stable(fwft_q));

  p_no_overrun_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (wbin - rptr) <= PW'(DEPTH));

  p_gray_single_step_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(sync_q[SYNC-1] ^ $past(sync_q[SYNC-1])) <= 1);

endmodule

// File: tb/test_fifo_rd_flag.sv
module test_fifo_rd_flag;
  localparam int DW = 32, DEPTH = 16, AW = 4, PW = 5;

  logic          rclk = 0, rrst_n = 0, fwft_sel = 1;
  logic [PW-1:0] wr_ptr_gray = '0;
  logic          rd_cs = 0, rd_dir = 0, rd_en = 0;
  logic [DW-1:0] ram_rdata;
  logic [AW-1:0] ram_raddr;
  logic          rd_inc, flag;
  logic [DW-1:0] dout;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr = '0;
  logic [DW-1:0] q[$];
  int errors = 0, checks = 0, inc_cnt = 0;
  bit pend = 0;

  always #5 rclk = ~rclk;
  assign ram_rdata = mem[ram_raddr];

  fifo_rd_flag #(.DW(DW), .DEPTH(DEPTH)) i_fifo_rd_flag (
    .rclk, .rrst_n, .fwft_sel, .wr_ptr_gray, .rd_cs, .rd_dir, .rd_en,
    .ram_rdata, .ram_raddr, .rd_inc, .dout, .flag);

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(posedge rclk); #6;
    mem[wptr[AW-1:0]] = d;
    q.push_back(d);
    wptr = wptr + 1'b1;
    wr_ptr_gray = wptr ^ (wptr >> 1);
  endtask

  task automatic set_req(input bit c, input bit d, input bit e);
    @(posedge rclk); #3;
    rd_cs = c; rd_dir = d; rd_en = e;
  endtask

  task automatic do_reset(input bit mode);
    rrst_n = 0; fwft_sel = mode;
    rd_cs = 0; rd_dir = 0; rd_en = 0;
    wptr = '0; wr_ptr_gray = '0; pend = 0; q.delete();
    repeat (3) @(posedge rclk);
    #3 rrst_n = 1;
  endtask

  task automatic after_edge();
    @(posedge rclk); #2;
  endtask

  // scoreboard monitor
  always @(negedge rclk) begin
    if (rrst_n) begin
      if (rd_inc) inc_cnt++;
      if (pend) begin
        pend = 0;
        if (q.size() == 0) check(0, "R8 read with empty queue", dout, '0);
        else begin
          automatic logic [DW-1:0] e = q.pop_front();
          check(dout === e, "R3/R8 plain-mode data", dout, e);
        end
      end
      if (rd_cs && rd_dir && rd_en && flag) begin
        if (!i_fifo_rd_flag_mode) pend = 1;
        else if (q.size() == 0) check(0, "R8 read with empty queue", dout, '0);
        else begin
          automatic logic [DW-1:0] e = q.pop_front();
          check(dout === e, "R8 look-ahead data", dout, e);
        end
      end
    end
  end

  bit i_fifo_rd_flag_mode = 1;

  initial begin
    repeat (200000) @(posedge rclk);
    check(0, "watchdog", '0, '0);
    report();
  end

  initial begin
    logic [AW-1:0] a0;
    int base;

    // ---------------- look-ahead mode ----------------
    i_fifo_rd_flag_mode = 1;
    do_reset(1);
    #1;
    check(flag === 0, "R1 flag after reset", flag, 0);
    check(dout === 0, "R1 dout after reset", dout, 0);
    check(rd_inc === 0, "R1 rd_inc after reset", rd_inc, 0);

    push(32'hA0A0_0001);
    after_edge(); check(flag === 0, "R2 flag at edge 1", flag, 0);
    after_edge(); check(flag === 0, "R2 flag at edge 2", flag, 0);
    after_edge(); check(flag === 1, "R2 flag at edge 3", flag, 1);
    check(dout === 32'hA0A0_0001, "R2 word preloaded", dout, 32'hA0A0_0001);

    repeat (3) after_edge();
    check(dout === 32'hA0A0_0001 && flag === 1, "R7 word held without read", dout, 32'hA0A0_0001);

    set_req(1, 1, 1);
    after_edge();
    check(flag === 0, "R6 flag falls on last read", flag, 0);
    rd_cs = 0;
    repeat (3) after_edge();
    check(dout === 32'hA0A0_0001, "R7 dout held while not ready", dout, 32'hA0A0_0001);

    a0 = ram_raddr;
    set_req(1, 1, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk);
      check(rd_inc === 0, "R5 no fetch when empty", rd_inc, 0);
    end
    check(ram_raddr === a0, "R5 address unchanged", ram_raddr, a0);
    check(flag === 0, "R5 flag stays low", flag, 0);
    set_req(0, 0, 0);

    push(32'hB0B0_0002);
    repeat (4) after_edge();
    check(flag === 1 && dout === 32'hB0B0_0002, "R4 second word shown", dout, 32'hB0B0_0002);
    set_req(0, 1, 1); after_edge();
    check(flag === 1 && dout === 32'hB0B0_0002, "R4 no select", dout, 32'hB0B0_0002);
    set_req(1, 0, 1); after_edge();
    check(flag === 1 && dout === 32'hB0B0_0002, "R4 write direction", dout, 32'hB0B0_0002);
    set_req(1, 1, 0); after_edge();
    check(flag === 1 && dout === 32'hB0B0_0002, "R4 no enable", dout, 32'hB0B0_0002);
    set_req(1, 1, 1); after_edge();
    check(flag === 0, "R4 full qualifier read", flag, 0);

    base = inc_cnt;
    for (int i = 0; i < 20; i++) push(32'hC000_0000 + i);
    repeat (8) after_edge();
    check(q.size() == 0, "R8 stream drained past wrap", q.size(), 0);
    check(flag === 0, "R6 flag low after stream", flag, 0);
    check(inc_cnt - base == 20, "R10 one fetch per word", inc_cnt - base, 20);
    check(ram_raddr === AW'(22), "R10 address wrapped", ram_raddr, AW'(22));
    set_req(0, 0, 0);

    // ---------------- plain mode ----------------
    repeat (2) @(posedge rclk);
    i_fifo_rd_flag_mode = 0;
    do_reset(0);
    #1;
    check(flag === 0 && dout === 0, "R1 plain reset state", dout, 0);

    push(32'hD0D0_0003);
    after_edge(); check(flag === 0, "R3 flag at edge 1", flag, 0);
    after_edge(); check(flag === 0, "R3 flag at edge 2", flag, 0);
    after_edge(); check(flag === 1, "R3 flag at edge 3", flag, 1);
    check(dout === 0, "R3 no preload", dout, 0);

    set_req(1, 1, 1);
    after_edge();
    check(dout === 32'hD0D0_0003, "R3 word after read", dout, 32'hD0D0_0003);
    check(flag === 0, "R6 plain flag falls", flag, 0);
    set_req(0, 0, 0);

    fwft_sel = 1;
    push(32'hE0E0_0004);
    repeat (4) after_edge();
    check(flag === 1 && dout === 32'hD0D0_0003, "R9 mode change ignored", dout, 32'hD0D0_0003);
    set_req(1, 1, 1);
    after_edge();
    check(dout === 32'hE0E0_0004, "R9 plain read still needed", dout, 32'hE0E0_0004);
    set_req(0, 0, 0);

    for (int i = 0; i < 5; i++) push(32'hF000_0010 + i);
    set_req(1, 1, 1);
    repeat (10) after_edge();
    check(q.size() == 0, "R8 plain burst drained", q.size(), 0);
    check(flag === 0, "R6 flag low after burst", flag, 0);
    check(dout === 32'hF000_0014, "R8 last burst word", dout, 32'hF000_0014);
    set_req(0, 0, 0);

    repeat (3) @(posedge rclk);
    report();
  end
endmodule